// File: doc/BRIEF.md
# Xon/Xoff Software Flow Controller

This block runs in-band software flow control for a single serial channel. Every character the receiver delivers is compared against two programmable stop characters and two programmable go characters. A stop token freezes the local transmitter and a go token releases it. Recognised tokens are flagged for discard in the same cycle as the receive strobe, so the receive FIFO write logic can drop them. The block works in single-character mode, where only the first character of each pair is used, or in two-character mode, where the two characters must arrive as consecutive received characters. An optional relaxed mode lets any received character release a frozen transmitter.

On the other side of the link, the block watches the receive FIFO fill level. When the level reaches the stop threshold, it asks the transmitter to insert the stop character or pair. Once the level has drained to the resume threshold, it asks for the go character or pair. Both thresholds come from one packed register: the low field is the stop level and the high field is the resume level. Each field counts in units of four entries, which gives the two thresholds hysteresis. An insertion request is shown only while the transmitter reports that it sits between characters, and a character is taken on every clock edge at which the request is high. The serialiser gives an inserted character priority over the next FIFO byte.

Top module: `swfc_ctrl`

## Requirements
- R1: In single mode, a received character equal to `stop_a` is flagged by `rx_drop` in its strobe cycle, and `tx_hold` is 1 from the next clock edge.
- R2: In single mode, a received character equal to `go_a` is flagged by `rx_drop` and clears `tx_hold` at the next edge.
- R3: In pair mode, `stop_a` followed directly by `stop_b` sets `tx_hold`, and `go_a` followed directly by `go_b` clears it. Both characters of a pair are dropped, and the first character alone changes nothing.
- R4: In pair mode, any other character arriving after a first pair character cancels the pending pair. The first character stays dropped, and the interrupting character is then judged afresh, as data or as the start of a new pair.
- R5: With `cfg_any` set and `tx_hold` high, a non-token character clears `tx_hold` and is not dropped. With `cfg_any` clear, such a character leaves `tx_hold` unchanged.
- R6: With `cfg_any` set in pair mode while held, `go_a` releases the hold and is dropped, and a following `go_b` is passed on as data.
- R7: `off_evt` is high for exactly the one cycle after the edge at which a stop token is recognised.
- R8: When `rx_level` is at least 4 × `cfg_thresh[3:0]` and no stop has been sent yet, the block requests `stop_a` on `ins_char`, followed in pair mode by a request for `stop_b`.
- R9: After a stop has been sent, no further stop is requested. The block requests `go_a` (then `go_b` in pair mode) once `rx_level` is at most 4 × `cfg_thresh[7:4]`, and never requests go without a stop sent before it.
- R10: `ins_req` is never high while `tx_idle` is low.
- R11: During and right after reset, `tx_hold`, `off_evt` and `ins_req` are 0.
- R12: With `cfg_en` low, no character is dropped, `tx_hold` is 0 and no insertion is requested.
- R13: `rx_drop` is high only in a cycle where `rx_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Software flow control enable |
| cfg_pair | input | 1 | 1: two-character tokens, 0: single-character tokens |
| cfg_any | input | 1 | Any received character releases the hold |
| go_a | input | CW (8) | First go character |
| go_b | input | CW (8) | Second go character |
| stop_a | input | CW (8) | First stop character |
| stop_b | input | CW (8) | Second stop character |
| cfg_thresh | input | 2*TW (8) | [3:0] stop level / 4, [7:4] resume level / 4 |
| rx_valid | input | 1 | Received character strobe |
| rx_char | input | CW (8) | Received character |
| rx_level | input | LW (7) | Receive FIFO fill level |
| tx_idle | input | 1 | Transmitter is between characters |
| tx_hold | output | 1 | Suspend transmitter |
| off_evt | output | 1 | One-cycle pulse on a recognised stop token |
| rx_drop | output | 1 | Do not write the current character to the FIFO |
| ins_req | output | 1 | Insert `ins_char` now, ahead of FIFO data |
| ins_char | output | CW (8) | Flow control character to insert |

## Verification
A matcher left in the wrong pair-pending state shows up at the very next received character, as a wrong `rx_drop` in its strobe cycle or a wrong `tx_hold` one edge later. A wrong stop-sent memory in the insertion path appears at the next `tx_idle` window, as a repeated stop, a missing stop or a premature go on `ins_char`. The bench therefore probes each mode with back-to-back characters, including broken pairs, and steps the fill level across both threshold edges, one count at a time on each side.

// File: rtl/swfc_pkg.sv
package swfc_pkg;
    typedef enum logic [1:0] {M_IDLE, M_GO1, M_STOP1} match_st_e;
    typedef enum logic [1:0] {I_IDLE, I_STOP2, I_GO2} ins_st_e;

    typedef struct packed {
        match_st_e st;
        logic      hold;
        logic      evt;
    } match_s;

    typedef struct packed {
        ins_st_e st;
        logic    stop_sent;
    } ins_s;
endpackage

// File: rtl/swfc_match.sv
module swfc_match
    import swfc_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          pair,
    input  logic          any,
    input  logic          valid,
    input  logic [CW-1:0] ch,
    input  logic [CW-1:0] go_a,
    input  logic [CW-1:0] go_b,
    input  logic [CW-1:0] stop_a,
    input  logic [CW-1:0] stop_b,
    output logic          hold,
    output logic          evt,
    output logic          drop
);
    match_s m_d, m_q;
    logic   fresh;

    always_comb begin
        m_d     = m_q;
        m_d.evt = 1'b0;
        drop    = 1'b0;
        fresh   = 1'b0;
        if (!en) begin
            m_d.st   = M_IDLE;
            m_d.hold = 1'b0;
        end else if (valid) begin
            case (m_q.st)
                M_STOP1: begin
                    if (ch == stop_b) begin
                        m_d.hold = 1'b1;
                        m_d.evt  = 1'b1;
                        m_d.st   = M_IDLE;
                        drop     = 1'b1;
                    end else begin
                        fresh = 1'b1;
                    end
                end
                M_GO1: begin
                    if (ch == go_b) begin
                        m_d.hold = 1'b0;
                        m_d.st   = M_IDLE;
                        drop     = 1'b1;
                    end else begin
                        fresh = 1'b1;
                    end
                end
                default: fresh = 1'b1;
            endcase
            if (fresh) begin
                m_d.st = M_IDLE;
                if (ch == stop_a) begin
                    drop = 1'b1;
                    if (pair) begin
                        m_d.st = M_STOP1;
                    end else begin
                        m_d.hold = 1'b1;
                        m_d.evt  = 1'b1;
                    end
                end else if (ch == go_a) begin
                    drop = 1'b1;
                    if (!pair || (m_q.hold && any)) begin
                        m_d.hold = 1'b0;
                    end else begin
                        m_d.st = M_GO1;
                    end
                end else if (m_q.hold && any) begin
                    m_d.hold = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_q <= '{st: M_IDLE, hold: 1'b0, evt: 1'b0};
        end else begin
            m_q <= m_d;
        end
    end

    assign hold = m_q.hold;
    assign evt  = m_q.evt;
endmodule

// File: rtl/swfc_insert.sv
module swfc_insert
    import swfc_pkg::*;
#(
    parameter int CW = 8,
    parameter int TW = 4,
    parameter int TS = 2,
    parameter int LW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          pair,
    input  logic [LW-1:0] level,
    input  logic [2*TW-1:0] thresh,
    input  logic          tx_idle,
    input  logic [CW-1:0] go_a,
    input  logic [CW-1:0] go_b,
    input  logic [CW-1:0] stop_a,
    input  logic [CW-1:0] stop_b,
    output logic          req,
    output logic [CW-1:0] ch_out
);
    ins_s          s_d, s_q;
    logic [LW-1:0] stop_lvl, go_lvl;
    logic          need_stop, need_go, pend;

    assign stop_lvl = LW'(thresh[TW-1:0]) << TS;
    assign go_lvl   = LW'(thresh[2*TW-1:TW]) << TS;

    always_comb begin
        s_d       = s_q;
        pend      = 1'b0;
        ch_out    = '0;
        need_stop = !s_q.stop_sent && (level >= stop_lvl);
        need_go   = s_q.stop_sent && (level <= go_lvl);
        if (!en) begin
            s_d.st        = I_IDLE;
            s_d.stop_sent = 1'b0;
        end else begin
            case (s_q.st)
                I_STOP2: begin
                    pend   = 1'b1;
                    ch_out = stop_b;
                    if (tx_idle) s_d.st = I_IDLE;
                end
                I_GO2: begin
                    pend   = 1'b1;
                    ch_out = go_b;
                    if (tx_idle) s_d.st = I_IDLE;
                end
                default: begin
                    if (need_stop) begin
                        pend   = 1'b1;
                        ch_out = stop_a;
                        if (tx_idle) begin
                            s_d.stop_sent = 1'b1;
                            if (pair) s_d.st = I_STOP2;
                        end
                    end else if (need_go) begin
                        pend   = 1'b1;
                        ch_out = go_a;
                        if (tx_idle) begin
                            s_d.stop_sent = 1'b0;
                            if (pair) s_d.st = I_GO2;
                        end
                    end
                end
            endcase
        end
        req = pend && tx_idle;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: I_IDLE, stop_sent: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/swfc_ctrl.sv
module swfc_ctrl #(
    parameter int DEPTH = 64,
    parameter int CW    = 8,
    parameter int TW    = 4,
    parameter int TS    = 2,
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_en,
    input  logic            cfg_pair,
    input  logic            cfg_any,
    input  logic [CW-1:0]   go_a,
    input  logic [CW-1:0]   go_b,
    input  logic [CW-1:0]   stop_a,
    input  logic [CW-1:0]   stop_b,
    input  logic [2*TW-1:0] cfg_thresh,
    input  logic            rx_valid,
    input  logic [CW-1:0]   rx_char,
    input  logic [LW-1:0]   rx_level,
    input  logic            tx_idle,
    output logic            tx_hold,
    output logic            off_evt,
    output logic            rx_drop,
    output logic            ins_req,
    output logic [CW-1:0]   ins_char
);
    swfc_match #(.CW(CW)) u_match (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (cfg_en),
        .pair   (cfg_pair),
        .any    (cfg_any),
        .valid  (rx_valid),
        .ch     (rx_char),
        .go_a   (go_a),
        .go_b   (go_b),
        .stop_a (stop_a),
        .stop_b (stop_b),
        .hold   (tx_hold),
        .evt    (off_evt),
        .drop   (rx_drop)
    );

    swfc_insert #(.CW(CW), .TW(TW), .TS(TS), .LW(LW)) u_insert (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (cfg_en),
        .pair    (cfg_pair),
        .level   (rx_level),
        .thresh  (cfg_thresh),
        .tx_idle (tx_idle),
        .go_a    (go_a),
        .go_b    (go_b),
        .stop_a  (stop_a),
        .stop_b  (stop_b),
        .req     (ins_req),
        .ch_out  (ins_char)
    );
endmodule

// File: rtl/swfc_ctrl_chk.sv
module swfc_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic cfg_en,
    input logic rx_valid,
    input logic tx_idle,
    input logic tx_hold,
    input logic off_evt,
    input logic rx_drop,
    input logic ins_req
);
    // R1: a new hold is always caused by a dropped received character
    p_hold_rise_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_hold) |-> $past(rx_valid && rx_drop));

    // R5: a release comes from a received character or from disabling
    p_hold_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_hold) |-> $past(rx_valid || !cfg_en));

    // R7: the stop event coincides with an active hold
    p_evt_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        off_evt |-> tx_hold);

    // R10: insertion only between characters
    p_req_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ins_req |-> tx_idle);

    // R12: disabled block stays silent
    p_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_en |-> (!ins_req && !rx_drop));

    // R13: discard only with a strobe
    p_drop_valid_r13: assert property (@(posedge clk) disable iff (!rst_n)
        rx_drop |-> rx_valid);
endmodule

bind swfc_ctrl swfc_ctrl_chk u_chk (.*);

// File: tb/sim_swfc_ctrl.sv
module sim_swfc_ctrl;
    localparam int CLK_P = 10;
    localparam int LW    = 7;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_en = 1'b1, cfg_pair = 1'b0, cfg_any = 1'b0;
    logic [7:0] go_a = 8'h0D, go_b = 8'h11, stop_a = 8'h0F, stop_b = 8'h13;
    logic [7:0] cfg_thresh = {4'd8, 4'd15};
    logic       rx_valid = 1'b0;
    logic [7:0] rx_char = '0;
    logic [LW-1:0] rx_level = '0;
    logic       tx_idle = 1'b0;
    logic       tx_hold, off_evt, rx_drop, ins_req;
    logic [7:0] ins_char;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;
    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic [7:0] e_ch;
    string      e_tag;

    always #(CLK_P/2) clk = ~clk;

    swfc_ctrl u0 (.*);

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // scoreboard monitor: every transmitter-idle window is compared
    always @(negedge clk) begin
        if (rst_n && tx_idle) begin
            n_chk++;
            if (ins_req) begin
                if (exp_q.size() == 0) begin
                    n_err++;
                    $display("FAIL R9 unexpected insert: actual=%0h expected=none", ins_char);
                end else begin
                    e_ch  = exp_q.pop_front();
                    e_tag = tag_q.pop_front();
                    if (ins_char !== e_ch) begin
                        n_err++;
                        $display("FAIL %s: actual=%0h expected=%0h", e_tag, ins_char, e_ch);
                    end
                end
            end else if (exp_q.size() != 0) begin
                e_ch  = exp_q.pop_front();
                e_tag = tag_q.pop_front();
                n_err++;
                $display("FAIL %s missing insert: actual=none expected=%0h", e_tag, e_ch);
            end
        end
    end

    task automatic rx_byte(input logic [7:0] c, input logic exp_drop, input string tag);
        @(posedge clk); #1;
        rx_valid = 1'b1;
        rx_char  = c;
        @(negedge clk);
        chk({7'd0, rx_drop}, {7'd0, exp_drop}, tag);
        @(posedge clk); #1;
        rx_valid = 1'b0;
    endtask

    task automatic hold_is(input logic exp, input string tag);
        @(negedge clk);
        chk({7'd0, tx_hold}, {7'd0, exp}, tag);
    endtask

    task automatic idle_pulse(input logic exp, input logic [7:0] c, input string tag);
        @(posedge clk); #1;
        if (exp) begin
            exp_q.push_back(c);
            tag_q.push_back(tag);
        end
        tx_idle = 1'b1;
        @(negedge clk);
        @(posedge clk); #1;
        tx_idle = 1'b0;
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    initial begin
        #(CLK_P * 50000);
        if (!done) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog: actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        // R11 reset state
        repeat (2) @(negedge clk);
        chk({5'd0, tx_hold, off_evt, ins_req}, 8'd0, "R11 in reset");
        @(posedge clk); #1;
        rst_n = 1'b1;
        @(negedge clk);
        chk({5'd0, tx_hold, off_evt, ins_req}, 8'd0, "R11 after reset");

        // single mode tokens
        rx_byte(8'h0F, 1'b1, "R1 stop dropped");
        hold_is(1'b1, "R1 hold set");
        chk({7'd0, off_evt}, 8'd1, "R7 event high");
        @(negedge clk);
        chk({7'd0, off_evt}, 8'd0, "R7 event one cycle");
        rx_byte(8'h0D, 1'b1, "R2 go dropped");
        hold_is(1'b0, "R2 hold cleared");
        rx_byte(8'h41, 1'b0, "R13 data kept");
        hold_is(1'b0, "R13 hold unchanged");

        // resume on any character
        cfg_any = 1'b1;
        rx_byte(8'h0F, 1'b1, "R5 stop");
        hold_is(1'b1, "R5 held");
        rx_byte(8'h41, 1'b0, "R5 any char kept");
        hold_is(1'b0, "R5 any char releases");
        cfg_any = 1'b0;
        rx_byte(8'h0F, 1'b1, "R5 stop again");
        rx_byte(8'h41, 1'b0, "R5 strict data kept");
        hold_is(1'b1, "R5 strict stays held");
        rx_byte(8'h0D, 1'b1, "R2 go in strict");
        hold_is(1'b0, "R2 released");

        // pair mode
        cfg_pair = 1'b1;
        rx_byte(8'h0F, 1'b1, "R3 first stop dropped");
        hold_is(1'b0, "R3 first alone no hold");
        rx_byte(8'h13, 1'b1, "R3 second stop dropped");
        hold_is(1'b1, "R3 pair holds");
        chk({7'd0, off_evt}, 8'd1, "R7 pair event");
        rx_byte(8'h0D, 1'b1, "R3 first go dropped");
        hold_is(1'b1, "R3 first go alone");
        rx_byte(8'h11, 1'b1, "R3 second go dropped");
        hold_is(1'b0, "R3 pair releases");

        // broken pairs
        rx_byte(8'h0F, 1'b1, "R4 first stop");
        rx_byte(8'h41, 1'b0, "R4 breaker is data");
        rx_byte(8'h13, 1'b0, "R4 late second is data");
        hold_is(1'b0, "R4 no hold");
        rx_byte(8'h0F, 1'b1, "R4 first stop b");
        rx_byte(8'h0D, 1'b1, "R4 breaker starts go pair");
        rx_byte(8'h13, 1'b0, "R4 stop second after go1 is data");
        hold_is(1'b0, "R4 still no hold");

        // pair mode with any: stray second go is data
        cfg_any = 1'b1;
        rx_byte(8'h0F, 1'b1, "R6 stop1");
        rx_byte(8'h13, 1'b1, "R6 stop2");
        hold_is(1'b1, "R6 held");
        rx_byte(8'h0D, 1'b1, "R6 go1 resumes dropped");
        hold_is(1'b0, "R6 released by go1");
        rx_byte(8'h11, 1'b0, "R6 stray go2 kept");
        hold_is(1'b0, "R6 stays released");
        cfg_any  = 1'b0;
        cfg_pair = 1'b0;

        // disabled
        cfg_en = 1'b0;
        rx_byte(8'h0F, 1'b0, "R12 stop not dropped");
        hold_is(1'b0, "R12 no hold");
        rx_level = 7'd64;
        idle_pulse(1'b0, 8'h00, "R12 no insert");
        rx_level = 7'd0;
        cfg_en   = 1'b1;

        // single-character insertion with hysteresis
        rx_level = 7'd59;
        idle_pulse(1'b0, 8'h00, "R8 below stop level");
        rx_level = 7'd60;
        repeat (3) begin
            @(negedge clk);
            chk({7'd0, ins_req}, 8'd0, "R10 busy transmitter");
        end
        idle_pulse(1'b1, 8'h0F, "R8 stop inserted");
        idle_pulse(1'b0, 8'h00, "R9 no repeat stop");
        rx_level = 7'd33;
        idle_pulse(1'b0, 8'h00, "R9 above resume level");
        rx_level = 7'd32;
        idle_pulse(1'b1, 8'h0D, "R9 go inserted");
        idle_pulse(1'b0, 8'h00, "R9 no repeat go");

        // pair insertion
        cfg_pair = 1'b1;
        rx_level = 7'd64;
        idle_pulse(1'b1, 8'h0F, "R8 pair stop first");
        idle_pulse(1'b1, 8'h13, "R8 pair stop second");
        idle_pulse(1'b0, 8'h00, "R9 pair no repeat");
        rx_level = 7'd0;
        idle_pulse(1'b1, 8'h0D, "R9 pair go first");
        idle_pulse(1'b1, 8'h11, "R9 pair go second");
        idle_pulse(1'b0, 8'h00, "R9 pair done");

        @(negedge clk);
        chk(8'(exp_q.size()), 8'd0, "R8 scoreboard drained");
        done = 1'b1;
        summary();
        $finish;
    end
endmodule